// File: doc/BRIEF.md
# Variable Fractional Delay Interpolator (Cubic Polynomial Structure)

This block resamples a stream of signed fixed-point samples at a delay that can be varied in steps finer than one sample. It is placed ahead of a symbol sampler in a timing-recovery loop. The loop's phase accumulator supplies the delay word. The block returns the input signal as it would have been seen a fraction of a sample later. Each accepted input carries one 8-bit sample and one 6-bit delay word. The delay word is an unsigned fraction `d = in_delay / 64` in the range [0, 63/64].

Internally a four-entry tap line feeds four fixed coefficient sub-filters. Each sub-filter yields one coefficient of a cubic polynomial in `d`. The polynomial is evaluated with three chained multiply-adds in nested form. Because `d` only weights fixed sub-filter outputs, it may change on every sample and no coefficient is ever reloaded. The full-precision result is rounded once and clipped to the 8-bit output format.

The datapath is a straight two-register pipeline with no control states. The first register stage holds the tap line and the captured delay. The second register stage holds the output sample.

Top module: `farrow_fd_interp`

## Requirements
- R1: With taps x0 = newest accepted sample, then x1, x2 and x3 (oldest), each read as signed value/128, the output is y = ((c3·d + c2)·d + c1)·d + c0. The sub-filter outputs use exact coefficients in units of 1/64. c0 = 64·x1. c1 = -21·x0 - 32·x1 + 64·x2 - 11·x3. c2 = 32·x0 - 64·x1 + 32·x2. c3 = -11·x0 + 32·x1 - 32·x2 + 11·x3. Each ck is then divided by 64. These are the cubic Lagrange weights for a total delay of 1 + d.
- R2: When the delay word is 0, the output equals x1 (the sample accepted one before the newest) exactly.
- R3: The output is rounded to the nearest multiple of 1/128, with exact halves rounded toward +infinity. It is then presented on out_sample with out_valid high exactly 2 clock cycles after the cycle in which in_valid was high.
- R4: The tap line and the captured delay advance only on cycles with in_valid high. Values on in_sample and in_delay during other cycles have no effect on any later output.
- R5: A rounded result above 127/128 is output as 127 (0x7F). A rounded result below -1 is output as -128 (0x80).
- R6: The delay word applies only to the sample it arrives with. A different delay on every consecutive sample (ramps, steps) gives each output the value that R1 gives for its own delay.
- R7: A synchronous active-high rst clears all taps, out_valid and out_sample to zero. The first output after reset is computed with zero taps behind the new sample.
- R8: In cycles where out_valid is low, out_sample keeps the last value it presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_sample and in_delay for this cycle |
| in_sample | input | 8 | Signed input sample, value/128 |
| in_delay | input | 6 | Unsigned fractional delay, value/64 |
| out_valid | output | 1 | Output sample is new this cycle |
| out_sample | output | 8 | Signed interpolated sample, value/128 |

## Verification
Each result is due two rising edges after the edge that accepted its input. The bench drives inputs on falling edges and stamps every expected value with the falling-edge count at which it was driven. It accepts an output only at the falling edge two counts later, so an early or a late result fails the R3 check. Between results the bench checks at every falling edge that out_sample holds its previous value. Every expected output is computed from the bench's own history of accepted samples. Idle cycles, which carry junk on the inputs, leave that history unchanged.

// File: rtl/farrow_fd_pkg.sv
package farrow_fd_pkg;

    // Polynomial order and the number of taps each sub-filter reads.
    localparam int ORDER     = 3;
    localparam int NTAPS     = ORDER + 1;
    // Sub-filter coefficient format: signed, units of 1/64.
    localparam int COEF_W    = 8;
    localparam int COEF_FRAC = 6;

    // Coefficient of sub-filter k applied to tap j (tap 0 is the newest).
    // Cubic Lagrange weights for total delay 1+d, expanded in powers of d.
    function automatic int branch_coef(input int k, input int j);
        int v;
        v = 0;
        case (k * NTAPS + j)
            1:  v =  64;                    // c0: x1
            4:  v = -21;                    // c1
            5:  v = -32;
            6:  v =  64;
            7:  v = -11;
            8:  v =  32;                    // c2
            9:  v = -64;
            10: v =  32;
            12: v = -11;                    // c3
            13: v =  32;
            14: v = -32;
            15: v =  11;
            default: v = 0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/farrow_tapline.sv
module farrow_tapline #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] taps [N]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) taps[i] <= '0;
        end else if (shift) begin
            taps[0] <= din;
            for (int i = 1; i < N; i++) taps[i] <= taps[i-1];
        end
    end

    // R4: taps move only when a sample is accepted
    assert_taps_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !shift |=> ($stable(taps[0]) && $stable(taps[N-1])));

    assert_taps_shift_R4: assert property (@(posedge clk) disable iff (rst)
        shift |=> (taps[0] == $past(din)) && (taps[1] == $past(taps[0])));

endmodule

// File: rtl/farrow_branches.sv
module farrow_branches
    import farrow_fd_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = DW + COEF_W + 2
) (
    input  logic signed [DW-1:0] taps [NTAPS],
    output logic signed [CW-1:0] coef_out [NTAPS]
);

    for (genvar k = 0; k < NTAPS; k++) begin : g_branch
        always_comb begin
            logic signed [CW-1:0] sum;
            sum = '0;
            for (int j = 0; j < NTAPS; j++) begin
                sum = sum + CW'(taps[j]) * CW'(branch_coef(k, j));
            end
            coef_out[k] = sum;
        end
    end

endmodule

// File: rtl/farrow_horner.sv
module farrow_horner
    import farrow_fd_pkg::*;
#(
    parameter int CW    = 18,
    parameter int DF    = 6,
    parameter int ACC_W = CW + ORDER * (DF + 1) + 1
) (
    input  logic signed [CW-1:0]    coef_in [NTAPS],
    input  logic        [DF-1:0]    dly,
    output logic signed [ACC_W-1:0] acc_out
);

    logic signed [ACC_W-1:0] dsx;
    logic signed [ACC_W-1:0] acc [NTAPS];

    assign dsx    = $signed(ACC_W'(dly));
    assign acc[0] = ACC_W'(coef_in[ORDER]);

    // Nested evaluation: each step multiplies by d and adds the next
    // lower-order coefficient aligned to the grown fraction.
    for (genvar s = 0; s < ORDER; s++) begin : g_step
        assign acc[s+1] = acc[s] * dsx
                        + (ACC_W'(coef_in[ORDER-1-s]) <<< (DF * (s + 1)));
    end

    assign acc_out = acc[ORDER];

endmodule

// File: rtl/farrow_round_sat.sv
module farrow_round_sat #(
    parameter int ACC_W = 40,
    parameter int SH    = 24,
    parameter int DW    = 8
) (
    input  logic signed [ACC_W-1:0] acc_in,
    output logic signed [DW-1:0]    sample_out
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SH - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(1 << (DW - 1)));

    logic signed [ACC_W-1:0] rnd;

    assign rnd = (acc_in + HALF) >>> SH;

    always_comb begin
        if (rnd > MAXV)      sample_out = MAXV[DW-1:0];
        else if (rnd < MINV) sample_out = MINV[DW-1:0];
        else                 sample_out = rnd[DW-1:0];
    end

endmodule

// File: rtl/farrow_fd_interp.sv
module farrow_fd_interp
    import farrow_fd_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DELAY_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic [DELAY_W-1:0]       in_delay,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_sample
);

    localparam int CW    = DATA_W + COEF_W + 2;
    localparam int ACC_W = CW + ORDER * (DELAY_W + 1) + 1;
    localparam int SH    = COEF_FRAC + ORDER * DELAY_W;

    localparam logic signed [ACC_W-1:0] HALF_TH = ACC_W'(1) <<< (SH - 1);
    localparam logic signed [ACC_W-1:0] SAT_HI_TH =
        (ACC_W'((1 << (DATA_W - 1)) - 1) <<< SH) + HALF_TH;
    localparam logic signed [ACC_W-1:0] SAT_LO_TH =
        (ACC_W'(-(1 << (DATA_W - 1))) <<< SH) - HALF_TH;

    logic signed [DATA_W-1:0] taps [NTAPS];
    logic signed [CW-1:0]     coefs [NTAPS];
    logic signed [ACC_W-1:0]  poly;
    logic signed [DATA_W-1:0] sat_sample;
    logic [DELAY_W-1:0]       dly_q;
    logic                     stage1_vld;

    // Stage 1: tap line and delay captured together
    farrow_tapline #(.W(DATA_W), .N(NTAPS)) u_tapline (
        .clk   (clk),
        .rst   (rst),
        .shift (in_valid),
        .din   (in_sample),
        .taps  (taps)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_vld <= 1'b0;
            dly_q      <= '0;
        end else begin
            stage1_vld <= in_valid;
            if (in_valid) dly_q <= in_delay;
        end
    end

    farrow_branches #(.DW(DATA_W), .CW(CW)) u_branches (
        .taps     (taps),
        .coef_out (coefs)
    );

    farrow_horner #(.CW(CW), .DF(DELAY_W), .ACC_W(ACC_W)) u_horner (
        .coef_in (coefs),
        .dly     (dly_q),
        .acc_out (poly)
    );

    farrow_round_sat #(.ACC_W(ACC_W), .SH(SH), .DW(DATA_W)) u_round (
        .acc_in     (poly),
        .sample_out (sat_sample)
    );

    // Stage 2: output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= stage1_vld;
            if (stage1_vld) out_sample <= sat_sample;
        end
    end

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    assert_zero_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (stage1_vld && dly_q == '0) |=> out_sample == $past(taps[1]));

    assert_clip_high_R5: assert property (@(posedge clk) disable iff (rst)
        (stage1_vld && poly >= SAT_HI_TH) |=>
            out_sample == DATA_W'((1 << (DATA_W - 1)) - 1));

    assert_clip_low_R5: assert property (@(posedge clk) disable iff (rst)
        (stage1_vld && poly < SAT_LO_TH) |=>
            out_sample == DATA_W'(-(1 << (DATA_W - 1))));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !stage1_vld |=> $stable(out_sample));

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_sample == '0));

endmodule

// File: tb/tb_farrow_fd_interp.sv
module tb_farrow_fd_interp;

    localparam int CLK_PERIOD = 10;
    localparam int QN = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_sample = '0;
    logic [5:0]        in_delay = '0;
    logic              out_valid;
    logic signed [7:0] out_sample;

    farrow_fd_interp dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .in_delay   (in_delay),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    done    = 1'b0;
    int    hist [4];
    int    exp_val [QN];
    int    exp_cyc [QN];
    string exp_tag [QN];
    int    q_head = 0;
    int    q_tail = 0;
    int    last_out = 0;
    real   phase = 0.0;
    real   omega = 0.02;

    // Bench's own copy of the sub-filter weights from R1 (units of 1/64)
    function automatic int wt(input int k, input int j);
        int t [4][4];
        t[0] = '{  0,  64,   0,   0};
        t[1] = '{-21, -32,  64, -11};
        t[2] = '{ 32, -64,  32,   0};
        t[3] = '{-11,  32, -32,  11};
        return t[k][j];
    endfunction

    // Values are dyadic, so double arithmetic is exact here.
    function automatic int model(input int d);
        real c [4];
        real y, dr;
        int  r;
        for (int k = 0; k < 4; k++) begin
            c[k] = 0.0;
            for (int j = 0; j < 4; j++)
                c[k] = c[k] + real'(wt(k, j)) * real'(hist[j]) / 8192.0;
        end
        dr = real'(d) / 64.0;
        y  = ((c[3] * dr + c[2]) * dr + c[1]) * dr + c[0];
        r  = int'($floor(y * 128.0 + 0.5));
        if (r > 127)  r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // Called once at every falling edge
    task automatic monitor();
        cyc++;
        if (out_valid) begin
            if (q_head == q_tail) begin
                check("R3 unexpected out_valid", 1, 0);
            end else begin
                check({exp_tag[q_head % QN], " value"}, int'(out_sample), exp_val[q_head % QN]);
                check("R3 latency", cyc - exp_cyc[q_head % QN], 2);
                q_head++;
            end
            last_out = int'(out_sample);
        end else begin
            check("R8 hold", int'(out_sample), last_out);
        end
    endtask

    task automatic send(input int x, input int d, input string tag);
        @(negedge clk);
        monitor();
        in_valid  = 1'b1;
        in_sample = 8'(x);
        in_delay  = 6'(d);
        for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        exp_val[q_tail % QN] = (d == 0) ? hist[1] : model(d);
        exp_tag[q_tail % QN] = (d == 0) ? {tag, " R2"} : tag;
        exp_cyc[q_tail % QN] = cyc;
        q_tail++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            monitor();
            in_valid  = 1'b0;
            in_sample = 8'(cyc * 37 + 91);
            in_delay  = 6'(cyc * 13 + 5);
        end
    endtask

    function automatic int chirp();
        int v;
        v = int'(120.0 * $sin(phase));
        phase = phase + omega;
        omega = omega + 0.0015;
        if (omega > 2.8) omega = 0.02;
        return v;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int steps [8];
        steps = '{6, 22, 50, 36, 60, 16, 44, 29};
        for (int i = 0; i < 4; i++) hist[i] = 0;

        // R7: reset state
        repeat (3) @(negedge clk);
        check("R7 out_valid in reset", int'(out_valid), 0);
        check("R7 out_sample in reset", int'(out_sample), 0);
        rst = 1'b0;

        // R7: first result uses cleared taps (d=0 -> x1 = 0)
        send(100, 0, "R7 first after reset");
        send(-50, 40, "R7 second after reset");

        // R1: constant delay of about 0.3 on a chirp
        for (int n = 0; n < 200; n++) send(chirp(), 19, "R1 constant delay");

        // R2: zero delay stream returns x[n-1]
        for (int n = 0; n < 40; n++) send(chirp(), 0, "R2 zero delay");

        // R6: ramp over every delay code, eight times
        for (int n = 0; n < 512; n++) send(chirp(), n % 64, "R6 ramp");

        // R6: piecewise-constant steps
        for (int s = 0; s < 8; s++)
            for (int n = 0; n < 16; n++) send(chirp(), steps[s], "R6 steps");

        // R6: delay changes every sample with alternating extremes
        for (int n = 0; n < 64; n++) send(chirp(), (n % 2) ? 63 : n, "R6 toggling delay");

        // R4: gaps with junk on the inputs are ignored
        for (int n = 0; n < 96; n++) begin
            send(chirp(), (n * 11) % 64, "R4 gapped");
            if (n % 3 == 0) idle(2);
            if (n % 7 == 0) idle(1);
        end

        // R5: overshoot clips high then low
        send(-128, 5, "R5 load");
        send(127, 5, "R5 load");
        send(127, 5, "R5 load");
        send(-128, 32, "R5 clip high");
        send(127, 5, "R5 load");
        send(-128, 5, "R5 load");
        send(-128, 5, "R5 load");
        send(127, 32, "R5 clip low");
        check("R5 model high", hist[0] == 127 ? 1 : 0, 1);

        // R3/R8: drain and let outputs settle
        idle(6);
        check("R3 all results delivered", q_tail - q_head, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule